// File: doc/BRIEF.md
# Four-Phase Bus-to-Device Handshake Controller

This block sits between a bus master and a slow peripheral and runs every transfer as a pair of four-phase handshakes. The master asks for a read or a write by raising one of two request lines. The controller then sequences a strobe to the device and an enable for the data transceiver. It acknowledges the master once the transfer is safe, and it walks both sides back to zero before it accepts the next request.

Reads and writes order the transceiver enable and the device strobe in opposite ways. A read strobes the device first and opens the transceiver once the device has answered. A write opens the transceiver first, strobes the device, and closes the transceiver when the device answers. The idle state and the final return state show the same values on every external line. The controller keeps its own state to tell them apart, and it will not strobe the device again until the device acknowledge from the last transfer has dropped.

All three inputs pass through a two-flop synchronizer. Every output is a flop. A sticky error flag reports a master that raises both requests at once, and a device acknowledge that moves without a matching strobe change.

Top module: `hs_bridge`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dev_strobe`, `xcvr_en`, `bus_ack` and `proto_err` are 0 after that edge.
- R2: From idle, a rise of `rd_req` alone raises `dev_strobe` 3 cycles later. `xcvr_en` and `bus_ack` stay 0 until the device acknowledges.
- R3: In a read, `xcvr_en` rises 3 cycles after `dev_ack` rises, and `bus_ack` rises one cycle after `xcvr_en`.
- R4: In a read, `xcvr_en` falls 3 cycles after `rd_req` falls. `bus_ack` and `dev_strobe` then fall together one cycle later.
- R5: From idle, a rise of `wr_req` alone raises `xcvr_en` 3 cycles later and `dev_strobe` one cycle after that, while `bus_ack` stays 0.
- R6: In a write, `xcvr_en` falls 3 cycles after `dev_ack` rises while `dev_strobe` stays 1, and `bus_ack` rises one cycle later.
- R7: In a write, `bus_ack` and `dev_strobe` fall together 3 cycles after `wr_req` falls.
- R8: No new `dev_strobe` rise happens until `dev_ack` from the last transfer is seen low. If a request is already pending, the strobe rises 4 cycles after `dev_ack` falls.
- R9: If `rd_req` and `wr_req` are both high, `proto_err` goes to 1 three cycles later and no transfer starts. `proto_err` then stays 1 until reset.
- R10: `proto_err` goes to 1 three cycles after `dev_ack` rises while `dev_strobe` is 0, or falls while `dev_strobe` is 1. It stays 0 through well-formed transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_req | input | 1 | Read request from the bus master (asynchronous) |
| wr_req | input | 1 | Write request from the bus master (asynchronous) |
| dev_ack | input | 1 | Acknowledge from the device (asynchronous) |
| bus_ack | output | 1 | Transfer acknowledge to the bus master |
| dev_strobe | output | 1 | Strobe to the device |
| xcvr_en | output | 1 | Data transceiver enable |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
If the controller confuses the return state with idle, it strobes the device again while the old acknowledge is still high, or it flags a false error. Either shows at the ports within four cycles of the acknowledge falling. A wrong read/write branch reverses the order of the strobe and the enable, and that shows one to three cycles after the request. The bench sweeps device response delays and master release delays for both cycle kinds, and it checks every edge at its exact cycle.

// File: rtl/hs_pkg.sv
// Package: shared state encoding and output decode for the handshake bridge.
// Assumes: outputs are a pure function of the state, so they are registered
// together with it.
package hs_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_STB,
        S_RD_DATA,
        S_RD_ACK,
        S_RD_DROP,
        S_RD_RET,
        S_WR_EN,
        S_WR_STB,
        S_WR_XOFF,
        S_WR_ACK,
        S_WR_RET
    } hs_state_e;

    typedef struct packed {
        logic strobe;
        logic xcvr;
        logic ack;
    } hs_out_t;

    // Output levels held in each state.
    function automatic hs_out_t hs_decode(input hs_state_e st);
        hs_out_t o;
        o = '0;
        case (st)
            S_RD_STB:  o = '{strobe: 1'b1, xcvr: 1'b0, ack: 1'b0};
            S_RD_DATA: o = '{strobe: 1'b1, xcvr: 1'b1, ack: 1'b0};
            S_RD_ACK:  o = '{strobe: 1'b1, xcvr: 1'b1, ack: 1'b1};
            S_RD_DROP: o = '{strobe: 1'b1, xcvr: 1'b0, ack: 1'b1};
            S_WR_EN:   o = '{strobe: 1'b0, xcvr: 1'b1, ack: 1'b0};
            S_WR_STB:  o = '{strobe: 1'b1, xcvr: 1'b1, ack: 1'b0};
            S_WR_XOFF: o = '{strobe: 1'b1, xcvr: 1'b0, ack: 1'b0};
            S_WR_ACK:  o = '{strobe: 1'b1, xcvr: 1'b0, ack: 1'b1};
            default:   o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/hs_sync.sv
// Module: multi-stage flop synchronizer for a bundle of independent inputs.
// Assumes: each bit changes slowly compared with the clock. The bits are
// not related to each other (no bus coherency is implied).
module hs_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the raw inputs through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/hs_fsm.sv
// Module: read/write sequencer. It walks both handshakes, including the
// return-to-zero phases.
// Assumes: inputs are already synchronized. The return states are kept apart
// from idle by the state register, not by the external lines.
module hs_fsm
    import hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_s,
    input  logic wr_s,
    input  logic ack_s,
    output logic dev_strobe,
    output logic xcvr_en,
    output logic bus_ack
);

    hs_state_e state_q, state_d;
    hs_out_t   out_d;

    // Next-state choice for each phase of both cycles.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE: begin
                if (!ack_s && rd_s && !wr_s)      state_d = S_RD_STB;
                else if (!ack_s && wr_s && !rd_s) state_d = S_WR_EN;
            end
            S_RD_STB:  if (ack_s)  state_d = S_RD_DATA;
            S_RD_DATA:             state_d = S_RD_ACK;
            S_RD_ACK:  if (!rd_s)  state_d = S_RD_DROP;
            S_RD_DROP:             state_d = S_RD_RET;
            S_RD_RET:  if (!ack_s) state_d = S_IDLE;
            S_WR_EN:               state_d = S_WR_STB;
            S_WR_STB:  if (ack_s)  state_d = S_WR_XOFF;
            S_WR_XOFF:             state_d = S_WR_ACK;
            S_WR_ACK:  if (!wr_s)  state_d = S_WR_RET;
            S_WR_RET:  if (!ack_s) state_d = S_IDLE;
            default:               state_d = S_IDLE;
        endcase
    end

    assign out_d = hs_decode(state_d);

    // Register the state and its decoded outputs together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            dev_strobe <= 1'b0;
            xcvr_en    <= 1'b0;
            bus_ack    <= 1'b0;
        end else begin
            state_q    <= state_d;
            dev_strobe <= out_d.strobe;
            xcvr_en    <= out_d.xcvr;
            bus_ack    <= out_d.ack;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!dev_strobe && !xcvr_en && !bus_ack)); // R1

    AST_READ_XCVR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(xcvr_en) && dev_strobe) |-> $past(ack_s)); // R3

    AST_ACK_UNDER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack) |-> dev_strobe); // R3

    AST_STROBE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_strobe) |-> (xcvr_en == $past(xcvr_en))); // R5

    AST_RETURN_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_strobe) |-> $fell(bus_ack)); // R4

    AST_STROBE_WAITS_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_strobe) |-> !$past(ack_s)); // R8

    AST_NO_START_ON_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && rd_s && wr_s) |=> (state_q == S_IDLE)); // R9

endmodule

// File: rtl/hs_monitor.sv
// Module: sticky protocol checker for the master and device sides.
// Assumes: the device acknowledge may move only in answer to a strobe change
// (rise under a high strobe, fall under a low strobe).
module hs_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_s,
    input  logic wr_s,
    input  logic ack_s,
    input  logic dev_strobe,
    output logic proto_err
);

    logic ack_prev_q;
    logic clash;
    logic stray_rise;
    logic stray_fall;

    assign clash      = rd_s && wr_s;
    assign stray_rise = ack_s && !ack_prev_q && !dev_strobe;
    assign stray_fall = !ack_s && ack_prev_q && dev_strobe;

    // Track the previous acknowledge and latch any violation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_prev_q <= 1'b0;
            proto_err  <= 1'b0;
        end else begin
            ack_prev_q <= ack_s;
            if (clash || stray_rise || stray_fall) proto_err <= 1'b1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err); // R9

    AST_ERR_ON_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        clash |=> proto_err); // R9

    AST_ERR_ON_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (stray_rise || stray_fall) |=> proto_err); // R10

endmodule

// File: rtl/hs_bridge.sv
// Module: top of the four-phase handshake bridge between a bus master and a
// slow device.
// Assumes: the inputs are asynchronous and go through SYNC_STAGES flops.
// All outputs are registered.
module hs_bridge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_req,
    input  logic dev_ack,
    output logic bus_ack,
    output logic dev_strobe,
    output logic xcvr_en,
    output logic proto_err
);

    localparam int N_IN = 3;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] sync_in;

    assign raw_in = {dev_ack, wr_req, rd_req};

    hs_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (sync_in)
    );

    hs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_s       (sync_in[0]),
        .wr_s       (sync_in[1]),
        .ack_s      (sync_in[2]),
        .dev_strobe (dev_strobe),
        .xcvr_en    (xcvr_en),
        .bus_ack    (bus_ack)
    );

    hs_monitor u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_s       (sync_in[0]),
        .wr_s       (sync_in[1]),
        .ack_s      (sync_in[2]),
        .dev_strobe (dev_strobe),
        .proto_err  (proto_err)
    );

endmodule

// File: tb/hs_bridge_bench.sv
// Bench: sweeps the device and master delays over read and write cycles,
// then drives the protocol-violation cases. Inputs change on the falling
// edge and outputs are sampled there.
module hs_bridge_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;

    logic clk = 1'b0;
    logic rst_n, rd_req, wr_req, dev_ack;
    logic bus_ack, dev_strobe, xcvr_en, proto_err;
    int   tests = 0;
    int   fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_bridge u_hs_bridge (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .dev_ack(dev_ack), .bus_ack(bus_ack), .dev_strobe(dev_strobe),
        .xcvr_en(xcvr_en), .proto_err(proto_err)
    );

    // Select output: 0 strobe, 1 transceiver enable, 2 bus ack, 3 error.
    function automatic logic get_out(input int which);
        case (which)
            0:       return dev_strobe;
            1:       return xcvr_en;
            2:       return bus_ack;
            default: return proto_err;
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Count falling edges until the output reaches val; compare with exp.
    task automatic wait_chk(input int which, input logic val, input int exp, input string tag);
        int n = 0;
        while (get_out(which) !== val && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(get_out(which) === val && n == exp, tag, n, exp);
    endtask

    task automatic do_reset;
        rst_n = 1'b0; rd_req = 1'b0; wr_req = 1'b0; dev_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check({dev_strobe, xcvr_en, bus_ack, proto_err} == 4'b0, "R1 reset state",
              int'({dev_strobe, xcvr_en, bus_ack, proto_err}), 0);
    endtask

    task automatic rd_cycle(input int dd, input int rel);
        rd_req = 1'b1;
        wait_chk(0, 1'b1, LAT, "R2 read strobe rise");
        repeat (dd) @(negedge clk);
        check(!xcvr_en && !bus_ack, "R2 no enable before device ack",
              int'({xcvr_en, bus_ack}), 0);
        dev_ack = 1'b1;
        wait_chk(1, 1'b1, LAT, "R3 read enable rise");
        wait_chk(2, 1'b1, 1, "R3 read bus ack rise");
        repeat (rel) @(negedge clk);
        rd_req = 1'b0;
        wait_chk(1, 1'b0, LAT, "R4 read enable fall");
        check(bus_ack && dev_strobe, "R4 ack and strobe held", int'({bus_ack, dev_strobe}), 3);
        wait_chk(2, 1'b0, 1, "R4 read ack fall");
        check(!dev_strobe, "R4 strobe falls with ack", int'(dev_strobe), 0);
        repeat (dd) @(negedge clk);
        dev_ack = 1'b0;
        repeat (4) @(negedge clk);
        check(!proto_err, "R10 no error on clean read", int'(proto_err), 0);
    endtask

    task automatic wr_cycle(input int dd, input int rel);
        wr_req = 1'b1;
        wait_chk(1, 1'b1, LAT, "R5 write enable rise");
        check(!dev_strobe, "R5 strobe after enable", int'(dev_strobe), 0);
        wait_chk(0, 1'b1, 1, "R5 write strobe rise");
        check(!bus_ack, "R5 no bus ack yet", int'(bus_ack), 0);
        repeat (dd) @(negedge clk);
        dev_ack = 1'b1;
        wait_chk(1, 1'b0, LAT, "R6 write enable fall");
        check(dev_strobe && !bus_ack, "R6 strobe held, ack low", int'({dev_strobe, bus_ack}), 2);
        wait_chk(2, 1'b1, 1, "R6 write bus ack rise");
        repeat (rel) @(negedge clk);
        wr_req = 1'b0;
        wait_chk(2, 1'b0, LAT, "R7 write ack fall");
        check(!dev_strobe, "R7 strobe falls with ack", int'(dev_strobe), 0);
        repeat (dd) @(negedge clk);
        dev_ack = 1'b0;
        repeat (4) @(negedge clk);
        check(!proto_err, "R10 no error on clean write", int'(proto_err), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        for (int dd = 0; dd < 4; dd++) begin
            for (int rel = 0; rel < 4; rel++) begin
                rd_cycle(dd, rel);
                wr_cycle(dd, rel);
            end
        end

        // R8: a pending read waits for the old device ack to drop.
        rd_req = 1'b1;
        wait_chk(0, 1'b1, LAT, "R8 first strobe");
        dev_ack = 1'b1;
        wait_chk(2, 1'b1, LAT + 1, "R8 first ack");
        rd_req = 1'b0;
        wait_chk(0, 1'b0, LAT + 1, "R8 strobe fall");
        rd_req = 1'b1;
        repeat (6) @(negedge clk);
        check(!dev_strobe, "R8 strobe held off while ack high", int'(dev_strobe), 0);
        dev_ack = 1'b0;
        wait_chk(0, 1'b1, LAT + 1, "R8 strobe after ack low");
        check(!proto_err, "R10 no error in back-to-back", int'(proto_err), 0);

        // R9: both requests together.
        do_reset();
        rd_req = 1'b1; wr_req = 1'b1;
        wait_chk(3, 1'b1, LAT, "R9 clash error");
        repeat (4) @(negedge clk);
        check(!dev_strobe && !xcvr_en && !bus_ack, "R9 no transfer on clash",
              int'({dev_strobe, xcvr_en, bus_ack}), 0);
        rd_req = 1'b0; wr_req = 1'b0;
        repeat (6) @(negedge clk);
        check(proto_err, "R9 error sticky", int'(proto_err), 1);

        // R10: ack rises with no strobe.
        do_reset();
        dev_ack = 1'b1;
        wait_chk(3, 1'b1, LAT, "R10 stray ack rise");
        dev_ack = 1'b0;
        repeat (4) @(negedge clk);

        // R10: ack falls while the strobe is still high.
        do_reset();
        rd_req = 1'b1;
        wait_chk(0, 1'b1, LAT, "R10 setup strobe");
        dev_ack = 1'b1;
        wait_chk(1, 1'b1, LAT, "R10 setup enable");
        dev_ack = 1'b0;
        wait_chk(3, 1'b1, LAT, "R10 stray ack fall");

        do_reset();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule